// File: doc/BRIEF.md
# D-PHY Bring-Up Sequencer

This block walks a MIPI D-PHY from a cleared, powered-down state to a running link. It is handed a set of timing and PLL values that have already been computed, plus a lane count. On a start pulse it first drops every PHY control line and pulses the test-port clear. It then streams its timing and configuration bytes, one write at a time, to an external test-port writer over a request/done handshake. After the last write it raises the PHY control lines one by one, with a settle delay after each. Last, it polls the PLL-lock and clock-lane stop-state indications until one of them shows up or the poll budget runs out.

Writes go out in a fixed order. The clock lane comes first, then one identical block of seven writes per data lane, taken in lane order, then six PHY/PLL configuration bytes. Every byte carries an address taken from a fixed map, and the writer decodes that address. All delays are counted in system clocks, so the same design runs with short windows in simulation and long ones in silicon. A lane count outside 1 to 4 is refused before anything is touched.

Top module: `dphy_bringup_seq`

## Requirements
- R1: A start with `lane_cnt` equal to 0 or greater than 4 sets `lane_err`. In that case no write request and no `tp_clear` pulse follow, and `ready` and `timeout` are low.
- R2: An accepted start drives `phy_enclk`, `phy_shutdn_n` and `phy_rst_n` to 0. `tp_clear` is high for exactly one cycle, and that cycle comes before the first write request.
- R3: The first five writes target the clock lane at addresses 0x10 to 0x14. They carry, in order, LPX, HS-prepare, HS-zero, HS-trail and wakeup.
- R4: For each lane i from 0 to lane_cnt-1 there follow seven writes at addresses 0x20+16*i+k, k=0..6. They carry the clock-lane LPX, data HS-prepare, data HS-zero, data HS-trail, the value 3, the value 4 and wakeup.
- R5: The wakeup byte written to every lane is the 16-bit `wakeup` input saturated to 0xFF.
- R6: Six configuration writes follow at 0x60 to 0x65, in this order:
  - 0x60 carries {5'b0, hstx_sel}.
  - 0x61 carries {2'b0, div5f, div1f, fbd2p[2:0], enbwt}.
  - 0x62 carries fbdp.
  - 0x63 carries fbds.
  - 0x64 carries {prediv1p, prep[6:0]}.
  - 0x65 carries {3'b101, vco750, lpfrs[1:0], lpfcs[1:0]}.
- R7: `wr_req` stays high with `wr_addr` and `wr_data` stable until `wr_done` is sampled high. Each item is requested exactly once, and the total count is 11+7*lane_cnt.
- R8: The control lines stay low during the writes. `phy_enclk` rises after the last write completes. `phy_shutdn_n` rises exactly SETTLE_CYC cycles later, and `phy_rst_n` rises exactly SETTLE_CYC cycles after that.
- R9: The first status poll happens LONG_CYC+1 cycles after `phy_rst_n` rises. Further polls follow every POLL_GAP+1 cycles. `ready` is set at the first poll that sees `phy_pll_lock` or `phy_clk_stop` high.
- R10: If POLL_MAX polls all fail, `timeout` is set exactly LONG_CYC+1+(POLL_MAX-1)*(POLL_GAP+1) cycles after `phy_rst_n` rises.
- R11: `ready` and `timeout` are never high together, and each holds until the next accepted start. A start that arrives while a bring-up is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up (one-cycle pulse) |
| lane_cnt | input | 3 | Number of data lanes, valid 1..4 |
| clk_lpx | input | 8 | LPX timing, shared by clock and data lanes |
| clk_hs_prep | input | 8 | Clock-lane HS-prepare |
| clk_hs_zero | input | 8 | Clock-lane HS-zero |
| clk_hs_trail | input | 8 | Clock-lane HS-trail |
| wakeup | input | 16 | Wakeup count before saturation |
| dat_hs_prep | input | 8 | Data-lane HS-prepare |
| dat_hs_zero | input | 8 | Data-lane HS-zero |
| dat_hs_trail | input | 8 | Data-lane HS-trail |
| hstx_sel | input | 3 | HS transmit clock select |
| pll_div5f | input | 1 | PLL feedback divide-by-5 flag |
| pll_div1f | input | 1 | PLL feedback divide-by-1 flag |
| pll_fbd2p | input | 3 | PLL feedback 2P field |
| pll_enbwt | input | 1 | PLL bandwidth enable |
| pll_fbdp | input | 8 | PLL feedback P divider |
| pll_fbds | input | 8 | PLL feedback S divider |
| pll_prediv1p | input | 1 | PLL pre-divider bypass |
| pll_prep | input | 7 | PLL pre-divider value |
| pll_vco750 | input | 1 | VCO 750 MHz range select |
| pll_lpfrs | input | 2 | Loop-filter resistor select |
| pll_lpfcs | input | 2 | Loop-filter capacitor select |
| wr_req | output | 1 | Test-port write request |
| wr_addr | output | 8 | Test-port register address |
| wr_data | output | 8 | Test-port write data |
| wr_done | input | 1 | Writer has taken the current item |
| tp_clear | output | 1 | Test-port clear pulse |
| phy_pll_lock | input | 1 | PHY PLL locked indication |
| phy_clk_stop | input | 1 | PHY clock lane in stop state |
| phy_enclk | output | 1 | PHY clock enable |
| phy_shutdn_n | output | 1 | PHY shutdown, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| ready | output | 1 | PHY reported ready |
| timeout | output | 1 | Poll budget exhausted |
| lane_err | output | 1 | Start refused: bad lane count |

## Verification
The properties assume a writer that raises `wr_done` only while `wr_req` is high and drops it again after one cycle. They also assume that the parameter inputs are not changed during a run, although the block latches them at start. The bench writer honours this: it answers each request after a chosen number of wait cycles and pulses done for a single cycle. The bench changes parameters only between runs, and it changes the status inputs only during the polling phase or ahead of a start.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    localparam int DW          = 8;
    localparam int CLK_STEPS   = 5;
    localparam int DAT_STEPS   = 7;
    localparam int CFG_STEPS   = 6;

    localparam logic [DW-1:0] CLK_BASE   = 8'h10;
    localparam logic [DW-1:0] DAT_BASE   = 8'h20;
    localparam logic [DW-1:0] DAT_STRIDE = 8'h10;
    localparam logic [DW-1:0] CFG_BASE   = 8'h60;
    localparam logic [DW-1:0] TA_GO_VAL  = 8'd3;
    localparam logic [DW-1:0] TA_GET_VAL = 8'd4;
    localparam logic [2:0]    PLL5_TAG   = 3'd5;

    typedef enum logic [1:0] {G_CLK, G_DAT, G_CFG} grp_e;

    typedef struct packed {
        logic [DW-1:0] lpx;
        logic [DW-1:0] clk_prep;
        logic [DW-1:0] clk_zero;
        logic [DW-1:0] clk_trail;
        logic [DW-1:0] wake;
        logic [DW-1:0] dat_prep;
        logic [DW-1:0] dat_zero;
        logic [DW-1:0] dat_trail;
        logic [2:0]    hstx_sel;
        logic          div5f;
        logic          div1f;
        logic [2:0]    fbd2p;
        logic          enbwt;
        logic [DW-1:0] fbdp;
        logic [DW-1:0] fbds;
        logic          prediv1p;
        logic [6:0]    prep;
        logic          vco750;
        logic [1:0]    lpfrs;
        logic [1:0]    lpfcs;
    } dphy_cfg_t;

    function automatic logic [DW-1:0] sat_byte(input logic [15:0] v);
        return (v > 16'h00FF) ? 8'hFF : v[7:0];
    endfunction

    function automatic logic [2:0] last_step(input grp_e g);
        case (g)
            G_CLK:   return 3'(CLK_STEPS - 1);
            G_DAT:   return 3'(DAT_STEPS - 1);
            default: return 3'(CFG_STEPS - 1);
        endcase
    endfunction

    function automatic logic [DW-1:0] step_addr(input grp_e g, input logic [DW-1:0] lane,
                                                input logic [2:0] k);
        case (g)
            G_CLK:   return CLK_BASE + 8'(k);
            G_DAT:   return DAT_BASE + lane * DAT_STRIDE + 8'(k);
            default: return CFG_BASE + 8'(k);
        endcase
    endfunction

    function automatic logic [DW-1:0] step_data(input grp_e g, input logic [2:0] k,
                                                input dphy_cfg_t c);
        logic [DW-1:0] r;
        r = '0;
        case (g)
            G_CLK: case (k)
                3'd0:    r = c.lpx;
                3'd1:    r = c.clk_prep;
                3'd2:    r = c.clk_zero;
                3'd3:    r = c.clk_trail;
                default: r = c.wake;
            endcase
            G_DAT: case (k)
                3'd0:    r = c.lpx;
                3'd1:    r = c.dat_prep;
                3'd2:    r = c.dat_zero;
                3'd3:    r = c.dat_trail;
                3'd4:    r = TA_GO_VAL;
                3'd5:    r = TA_GET_VAL;
                default: r = c.wake;
            endcase
            default: case (k)
                3'd0:    r = {5'b0, c.hstx_sel};
                3'd1:    r = {2'b0, c.div5f, c.div1f, c.fbd2p, c.enbwt};
                3'd2:    r = c.fbdp;
                3'd3:    r = c.fbds;
                3'd4:    r = {c.prediv1p, c.prep};
                default: r = {PLL5_TAG, c.vco750, c.lpfrs, c.lpfcs};
            endcase
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dphy_wr_sched.sv
module dphy_wr_sched
    import dphy_seq_pkg::*;
#(
    parameter int MAX_LANES = 4,
    localparam int LANE_W   = $clog2(MAX_LANES + 1),
    localparam int LIDX_W   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LANE_W-1:0] lanes,
    input  dphy_cfg_t         cfg,
    input  logic              wr_done,
    output logic              wr_req,
    output logic [DW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              all_done
);

    logic              active;
    grp_e              grp;
    logic [LIDX_W-1:0] lane;
    logic [2:0]        k;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            grp      <= G_CLK;
            lane     <= '0;
            k        <= '0;
            all_done <= 1'b0;
        end else begin
            all_done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                grp    <= G_CLK;
                lane   <= '0;
                k      <= '0;
            end else if (active && wr_done) begin
                if (k == last_step(grp)) begin
                    k <= '0;
                    case (grp)
                        G_CLK: grp <= G_DAT;
                        G_DAT: begin
                            if (LANE_W'(lane) == lanes - LANE_W'(1)) begin
                                lane <= '0;
                                grp  <= G_CFG;
                            end else begin
                                lane <= lane + 1'b1;
                            end
                        end
                        default: begin
                            active   <= 1'b0;
                            all_done <= 1'b1;
                        end
                    endcase
                end else begin
                    k <= k + 3'd1;
                end
            end
        end
    end

    assign wr_req  = active;
    assign wr_addr = step_addr(grp, DW'(lane), k);
    assign wr_data = step_data(grp, k, cfg);

endmodule

// File: rtl/dphy_pwr_ctrl.sv
module dphy_pwr_ctrl #(
    parameter int SETTLE_CYC = 8,
    parameter int LONG_CYC   = 64,
    parameter int POLL_GAP   = 16,
    parameter int POLL_MAX   = 100,
    localparam int MAXD      = (SETTLE_CYC > LONG_CYC)
                               ? ((SETTLE_CYC > POLL_GAP) ? SETTLE_CYC : POLL_GAP)
                               : ((LONG_CYC > POLL_GAP) ? LONG_CYC : POLL_GAP),
    localparam int CW        = $clog2(MAXD + 1),
    localparam int PW        = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic go,
    input  logic stat_ok,
    output logic enclk,
    output logic shdn_n,
    output logic rst_n,
    output logic ready,
    output logic timeout
);

    typedef enum logic [2:0] {P_IDLE, P_W_EN, P_W_SD, P_W_RST, P_POLL, P_GAP, P_END} pst_e;

    pst_e          st;
    logic [CW-1:0] cnt;
    logic [PW-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st      <= P_IDLE;
            cnt     <= '0;
            polls   <= '0;
            enclk   <= 1'b0;
            shdn_n  <= 1'b0;
            rst_n   <= 1'b0;
            ready   <= 1'b0;
            timeout <= 1'b0;
        end else begin
            case (st)
                P_IDLE: if (go) begin
                    enclk <= 1'b1;
                    cnt   <= CW'(SETTLE_CYC - 1);
                    polls <= '0;
                    st    <= P_W_EN;
                end
                P_W_EN: if (cnt == '0) begin
                    shdn_n <= 1'b1;
                    cnt    <= CW'(SETTLE_CYC - 1);
                    st     <= P_W_SD;
                end else cnt <= cnt - 1'b1;
                P_W_SD: if (cnt == '0) begin
                    rst_n <= 1'b1;
                    cnt   <= CW'(LONG_CYC - 1);
                    st    <= P_W_RST;
                end else cnt <= cnt - 1'b1;
                P_W_RST: if (cnt == '0) st <= P_POLL;
                         else cnt <= cnt - 1'b1;
                P_POLL: begin
                    if (stat_ok) begin
                        ready <= 1'b1;
                        st    <= P_END;
                    end else if (polls == PW'(POLL_MAX - 1)) begin
                        timeout <= 1'b1;
                        st      <= P_END;
                    end else begin
                        polls <= polls + 1'b1;
                        cnt   <= CW'(POLL_GAP - 1);
                        st    <= P_GAP;
                    end
                end
                P_GAP: if (cnt == '0) st <= P_POLL;
                       else cnt <= cnt - 1'b1;
                default: st <= P_END;
            endcase
        end
    end

endmodule

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq
    import dphy_seq_pkg::*;
#(
    parameter int MAX_LANES  = 4,
    parameter int SETTLE_CYC = 8,
    parameter int LONG_CYC   = 64,
    parameter int POLL_GAP   = 16,
    parameter int POLL_MAX   = 100,
    localparam int LANE_W    = $clog2(MAX_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANE_W-1:0] lane_cnt,
    input  logic [7:0]        clk_lpx,
    input  logic [7:0]        clk_hs_prep,
    input  logic [7:0]        clk_hs_zero,
    input  logic [7:0]        clk_hs_trail,
    input  logic [15:0]       wakeup,
    input  logic [7:0]        dat_hs_prep,
    input  logic [7:0]        dat_hs_zero,
    input  logic [7:0]        dat_hs_trail,
    input  logic [2:0]        hstx_sel,
    input  logic              pll_div5f,
    input  logic              pll_div1f,
    input  logic [2:0]        pll_fbd2p,
    input  logic              pll_enbwt,
    input  logic [7:0]        pll_fbdp,
    input  logic [7:0]        pll_fbds,
    input  logic              pll_prediv1p,
    input  logic [6:0]        pll_prep,
    input  logic              pll_vco750,
    input  logic [1:0]        pll_lpfrs,
    input  logic [1:0]        pll_lpfcs,
    output logic              wr_req,
    output logic [7:0]        wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_done,
    output logic              tp_clear,
    input  logic              phy_pll_lock,
    input  logic              phy_clk_stop,
    output logic              phy_enclk,
    output logic              phy_shutdn_n,
    output logic              phy_rst_n,
    output logic              ready,
    output logic              timeout,
    output logic              lane_err
);

    typedef enum logic [1:0] {T_IDLE, T_CLEAR, T_WRITE, T_POWER} top_e;

    top_e              phase;
    dphy_cfg_t         cfg_in, cfg_q;
    logic [LANE_W-1:0] lanes_q;
    logic              lanes_ok, accept, wr_all_done, pwr_go, pwr_clr;

    always_comb begin
        cfg_in           = '0;
        cfg_in.lpx       = clk_lpx;
        cfg_in.clk_prep  = clk_hs_prep;
        cfg_in.clk_zero  = clk_hs_zero;
        cfg_in.clk_trail = clk_hs_trail;
        cfg_in.wake      = sat_byte(wakeup);
        cfg_in.dat_prep  = dat_hs_prep;
        cfg_in.dat_zero  = dat_hs_zero;
        cfg_in.dat_trail = dat_hs_trail;
        cfg_in.hstx_sel  = hstx_sel;
        cfg_in.div5f     = pll_div5f;
        cfg_in.div1f     = pll_div1f;
        cfg_in.fbd2p     = pll_fbd2p;
        cfg_in.enbwt     = pll_enbwt;
        cfg_in.fbdp      = pll_fbdp;
        cfg_in.fbds      = pll_fbds;
        cfg_in.prediv1p  = pll_prediv1p;
        cfg_in.prep      = pll_prep;
        cfg_in.vco750    = pll_vco750;
        cfg_in.lpfrs     = pll_lpfrs;
        cfg_in.lpfcs     = pll_lpfcs;
    end

    assign lanes_ok = (lane_cnt != '0) && (lane_cnt <= LANE_W'(MAX_LANES));
    assign accept   = (phase == T_IDLE) && start;
    assign pwr_clr  = accept;
    assign pwr_go   = (phase == T_WRITE) && wr_all_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= T_IDLE;
            cfg_q    <= '0;
            lanes_q  <= '0;
            tp_clear <= 1'b0;
            lane_err <= 1'b0;
        end else begin
            tp_clear <= 1'b0;
            case (phase)
                T_IDLE: if (start) begin
                    if (lanes_ok) begin
                        lane_err <= 1'b0;
                        cfg_q    <= cfg_in;
                        lanes_q  <= lane_cnt;
                        tp_clear <= 1'b1;
                        phase    <= T_CLEAR;
                    end else begin
                        lane_err <= 1'b1;
                    end
                end
                T_CLEAR: phase <= T_WRITE;
                T_WRITE: if (wr_all_done) phase <= T_POWER;
                default: if (ready || timeout) phase <= T_IDLE;
            endcase
        end
    end

    dphy_wr_sched #(.MAX_LANES(MAX_LANES)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .go       (phase == T_CLEAR),
        .lanes    (lanes_q),
        .cfg      (cfg_q),
        .wr_done  (wr_done),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .all_done (wr_all_done)
    );

    dphy_pwr_ctrl #(
        .SETTLE_CYC (SETTLE_CYC),
        .LONG_CYC   (LONG_CYC),
        .POLL_GAP   (POLL_GAP),
        .POLL_MAX   (POLL_MAX)
    ) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .clear   (pwr_clr),
        .go      (pwr_go),
        .stat_ok (phy_pll_lock | phy_clk_stop),
        .enclk   (phy_enclk),
        .shdn_n  (phy_shutdn_n),
        .rst_n   (phy_rst_n),
        .ready   (ready),
        .timeout (timeout)
    );

endmodule

// File: rtl/dphy_seq_chk.sv
module dphy_seq_chk
    import dphy_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_req,
    input logic       wr_done,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       tp_clear,
    input logic       phy_enclk,
    input logic       phy_shutdn_n,
    input logic       phy_rst_n,
    input logic       ready,
    input logic       timeout,
    input logic       lane_err
);

    assert_lane_err_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        lane_err |-> (!wr_req && !tp_clear));

    assert_clear_before_write_R2: assert property (@(posedge clk) disable iff (rst)
        tp_clear |-> (!wr_req && !phy_enclk && !phy_shutdn_n && !phy_rst_n));

    assert_ta_go_value_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_addr[7:4] >= 4'd2 && wr_addr[7:4] <= 4'd5 && wr_addr[3:0] == 4'd4)
        |-> (wr_data == TA_GO_VAL));

    assert_pll5_tag_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_addr == CFG_BASE + 8'd5) |-> (wr_data[7:5] == PLL5_TAG));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_lines_low_writing_R8: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (!phy_enclk && !phy_shutdn_n && !phy_rst_n));

    assert_shdn_after_en_R8: assert property (@(posedge clk) disable iff (rst)
        phy_shutdn_n |-> phy_enclk);

    assert_rst_after_shdn_R8: assert property (@(posedge clk) disable iff (rst)
        phy_rst_n |-> phy_shutdn_n);

    assert_ready_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(ready && timeout));

    assert_ready_needs_rst_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> phy_rst_n);

endmodule

bind dphy_bringup_seq dphy_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_req       (wr_req),
    .wr_done      (wr_done),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .tp_clear     (tp_clear),
    .phy_enclk    (phy_enclk),
    .phy_shutdn_n (phy_shutdn_n),
    .phy_rst_n    (phy_rst_n),
    .ready        (ready),
    .timeout      (timeout),
    .lane_err     (lane_err)
);

// File: tb/test_dphy_bringup_seq.sv
module test_dphy_bringup_seq;

    localparam int SET  = 4;
    localparam int LNG  = 20;
    localparam int GAP  = 3;
    localparam int PMAX = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic start = 1'b0;
    logic [2:0] lane_cnt = 3'd1;
    logic [7:0] clk_lpx = 0, clk_hs_prep = 0, clk_hs_zero = 0, clk_hs_trail = 0;
    logic [15:0] wakeup = 0;
    logic [7:0] dat_hs_prep = 0, dat_hs_zero = 0, dat_hs_trail = 0;
    logic [2:0] hstx_sel = 0, pll_fbd2p = 0;
    logic pll_div5f = 0, pll_div1f = 0, pll_enbwt = 0, pll_prediv1p = 0, pll_vco750 = 0;
    logic [7:0] pll_fbdp = 0, pll_fbds = 0;
    logic [6:0] pll_prep = 0;
    logic [1:0] pll_lpfrs = 0, pll_lpfcs = 0;
    logic wr_req, tp_clear, phy_enclk, phy_shutdn_n, phy_rst_n, ready, timeout, lane_err;
    logic [7:0] wr_addr, wr_data;
    logic wr_done = 1'b0;
    logic phy_pll_lock = 1'b0, phy_clk_stop = 1'b0;

    dphy_bringup_seq #(.SETTLE_CYC(SET), .LONG_CYC(LNG), .POLL_GAP(GAP), .POLL_MAX(PMAX))
    i_dphy_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt),
        .clk_lpx(clk_lpx), .clk_hs_prep(clk_hs_prep), .clk_hs_zero(clk_hs_zero),
        .clk_hs_trail(clk_hs_trail), .wakeup(wakeup), .dat_hs_prep(dat_hs_prep),
        .dat_hs_zero(dat_hs_zero), .dat_hs_trail(dat_hs_trail), .hstx_sel(hstx_sel),
        .pll_div5f(pll_div5f), .pll_div1f(pll_div1f), .pll_fbd2p(pll_fbd2p),
        .pll_enbwt(pll_enbwt), .pll_fbdp(pll_fbdp), .pll_fbds(pll_fbds),
        .pll_prediv1p(pll_prediv1p), .pll_prep(pll_prep), .pll_vco750(pll_vco750),
        .pll_lpfrs(pll_lpfrs), .pll_lpfcs(pll_lpfcs),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
        .tp_clear(tp_clear), .phy_pll_lock(phy_pll_lock), .phy_clk_stop(phy_clk_stop),
        .phy_enclk(phy_enclk), .phy_shutdn_n(phy_shutdn_n), .phy_rst_n(phy_rst_n),
        .ready(ready), .timeout(timeout), .lane_err(lane_err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard of expected writes
    typedef struct { logic [7:0] a; logic [7:0] d; } item_t;
    item_t exp_q[$];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int lat = 0, wcnt = 0, n_wr = 0, n_clr = 0, last_wr = 0;
    int t_en = -1, t_sd = -1, t_rs = -1, t_rdy = -1, t_to = -1;
    bit p_en = 0, p_sd = 0, p_rs = 0, p_rdy = 0, p_to = 0;

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h14 || (a >= 8'h20 && a < 8'h60 && a[3:0] == 4'd6)) return "R5";
        if (a < 8'h20) return "R3";
        if (a < 8'h60) return "R4";
        return "R6";
    endfunction

    // monitor: writer responder and scoreboard pop
    initial begin
        forever begin
            @(negedge clk);
            if (tp_clear) begin
                n_clr++;
                chk(!phy_enclk && !phy_shutdn_n && !phy_rst_n, "R2 lines low at clear",
                    {phy_enclk, phy_shutdn_n, phy_rst_n}, 0);
            end
            if (phy_enclk && !p_en) t_en = cyc;
            if (phy_shutdn_n && !p_sd) t_sd = cyc;
            if (phy_rst_n && !p_rs) t_rs = cyc;
            if (ready && !p_rdy) t_rdy = cyc;
            if (timeout && !p_to) t_to = cyc;
            p_en = phy_enclk; p_sd = phy_shutdn_n; p_rs = phy_rst_n;
            p_rdy = ready; p_to = timeout;
            if (wr_done) wr_done = 1'b0;
            else if (wr_req) begin
                if (wcnt < lat) wcnt++;
                else begin
                    wcnt = 0;
                    if (n_clr == 0) chk(0, "R2 write before clear", wr_addr, 0);
                    chk(!phy_enclk && !phy_shutdn_n && !phy_rst_n, "R8 lines low while writing",
                        {phy_enclk, phy_shutdn_n, phy_rst_n}, 0);
                    if (exp_q.size() == 0) chk(0, "R7 unexpected write", wr_addr, 0);
                    else begin
                        item_t e;
                        e = exp_q.pop_front();
                        chk(wr_addr == e.a, "R7 write address", wr_addr, e.a);
                        chk(wr_data == e.d, tag_of(e.a), wr_data, e.d);
                    end
                    n_wr++;
                    last_wr = cyc;
                    wr_done = 1'b1;
                end
            end
        end
    end

    // driver: compute expected writes from the requirements
    task automatic load_expect(input int lanes);
        logic [7:0] wk;
        wk = (wakeup > 16'hFF) ? 8'hFF : wakeup[7:0];
        exp_q.push_back('{8'h10, clk_lpx});
        exp_q.push_back('{8'h11, clk_hs_prep});
        exp_q.push_back('{8'h12, clk_hs_zero});
        exp_q.push_back('{8'h13, clk_hs_trail});
        exp_q.push_back('{8'h14, wk});
        for (int i = 0; i < lanes; i++) begin
            logic [7:0] b;
            b = 8'h20 + 8'(i) * 8'h10;
            exp_q.push_back('{b + 8'd0, clk_lpx});
            exp_q.push_back('{b + 8'd1, dat_hs_prep});
            exp_q.push_back('{b + 8'd2, dat_hs_zero});
            exp_q.push_back('{b + 8'd3, dat_hs_trail});
            exp_q.push_back('{b + 8'd4, 8'd3});
            exp_q.push_back('{b + 8'd5, 8'd4});
            exp_q.push_back('{b + 8'd6, wk});
        end
        exp_q.push_back('{8'h60, {5'b0, hstx_sel}});
        exp_q.push_back('{8'h61, {2'b0, pll_div5f, pll_div1f, pll_fbd2p, pll_enbwt}});
        exp_q.push_back('{8'h62, pll_fbdp});
        exp_q.push_back('{8'h63, pll_fbds});
        exp_q.push_back('{8'h64, {pll_prediv1p, pll_prep}});
        exp_q.push_back('{8'h65, {3'b101, pll_vco750, pll_lpfrs, pll_lpfcs}});
    endtask

    task automatic set_params(input int seed);
        clk_lpx = 8'(seed * 3 + 1); clk_hs_prep = 8'(seed + 7); clk_hs_zero = 8'(seed * 5 + 2);
        clk_hs_trail = 8'(seed + 40); dat_hs_prep = 8'(seed * 7 + 9);
        dat_hs_zero = 8'(seed + 90); dat_hs_trail = 8'(seed * 11 + 3);
        hstx_sel = 3'(seed); pll_div5f = seed[0]; pll_div1f = ~seed[0];
        pll_fbd2p = 3'(seed + 2); pll_enbwt = 1'b1; pll_fbdp = 8'(seed * 13);
        pll_fbds = 8'(seed + 200); pll_prediv1p = seed[1]; pll_prep = 7'(seed * 9 + 5);
        pll_vco750 = seed[0]; pll_lpfrs = 2'(seed); pll_lpfcs = 2'(seed + 1);
    endtask

    task automatic pulse_start(input logic [2:0] lc);
        @(negedge clk);
        lane_cnt = lc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_fin(output bit ok);
        int i;
        i = 0; ok = 0;
        while (i < 5000 && !ok) begin
            @(negedge clk);
            if (ready || timeout) ok = 1;
            i++;
        end
    endtask

    task automatic clear_marks();
        t_en = -1; t_sd = -1; t_rs = -1; t_rdy = -1; t_to = -1;
        n_wr = 0; n_clr = 0;
    endtask

    task automatic run_ok(input int lanes, input int seed, input int l, input bit hit_busy,
                          output bit fin);
        set_params(seed);
        lat = l;
        clear_marks();
        load_expect(lanes);
        pulse_start(3'(lanes));
        if (hit_busy) begin
            repeat (6) @(negedge clk);
            pulse_start(3'd0); // R11: must be ignored while busy
        end
        wait_fin(fin);
        chk(fin, "R9 run completes", fin, 1);
        chk(exp_q.size() == 0, "R7 all items written", exp_q.size(), 0);
        chk(n_wr == 11 + 7 * lanes, "R7 write count", n_wr, 11 + 7 * lanes);
        chk(n_clr == 1, "R2 one clear pulse", n_clr, 1);
        chk(t_en > last_wr, "R8 enclk after last write", t_en, last_wr + 1);
        chk(t_sd - t_en == SET, "R8 shutdown_n settle", t_sd - t_en, SET);
        chk(t_rs - t_sd == SET, "R8 reset_n settle", t_rs - t_sd, SET);
        chk(!lane_err, "R11 busy start ignored", lane_err, 0);
        exp_q.delete();
    endtask

    initial begin
        bit fin;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!wr_req && !tp_clear && !phy_enclk && !phy_shutdn_n && !phy_rst_n,
            "R8 reset outputs", {wr_req, tp_clear, phy_enclk, phy_shutdn_n, phy_rst_n}, 0);
        chk(!ready && !timeout && !lane_err, "R11 reset flags", {ready, timeout, lane_err}, 0);

        // R1: bad lane counts
        clear_marks();
        pulse_start(3'd0);
        repeat (5) @(negedge clk);
        chk(lane_err && !ready && !timeout, "R1 lane 0 refused", {lane_err, ready, timeout}, 3'b100);
        chk(n_wr == 0 && n_clr == 0, "R1 lane 0 no activity", n_wr + n_clr, 0);
        pulse_start(3'd5);
        repeat (5) @(negedge clk);
        chk(lane_err && n_wr == 0 && n_clr == 0, "R1 lane 5 refused", lane_err, 1);

        // single lane, lock present from start: ready at first poll (R9)
        wakeup = 16'h0040;
        phy_pll_lock = 1'b1; phy_clk_stop = 1'b0;
        run_ok(1, 1, 0, 0, fin);
        chk(ready && !timeout, "R9 ready by lock", {ready, timeout}, 2'b10);
        chk(t_rdy - t_rs == LNG + 1, "R9 first poll time", t_rdy - t_rs, LNG + 1);
        repeat (10) @(negedge clk);
        chk(ready && !timeout, "R11 ready sticky", {ready, timeout}, 2'b10);

        // four lanes, wakeup saturated (R5), stop state appears late, busy start ignored
        wakeup = 16'h01F3;
        phy_pll_lock = 1'b0; phy_clk_stop = 1'b0;
        fork
            begin
                @(posedge phy_rst_n);
                repeat (LNG + 3 * (GAP + 1) + 2) @(negedge clk);
                phy_clk_stop = 1'b1;
            end
        join_none
        run_ok(4, 6, 2, 1, fin);
        chk(ready && !timeout, "R9 ready by stop state", {ready, timeout}, 2'b10);
        chk(t_rdy - t_rs > LNG + 1, "R9 ready only after status", t_rdy - t_rs, LNG + 2);

        // two lanes, no status: timeout (R10)
        wakeup = 16'h0100;
        phy_pll_lock = 1'b0; phy_clk_stop = 1'b0;
        run_ok(2, 3, 1, 0, fin);
        chk(timeout && !ready, "R10 timeout flagged", {ready, timeout}, 2'b01);
        chk(t_to - t_rs == LNG + 1 + (PMAX - 1) * (GAP + 1), "R10 timeout time",
            t_to - t_rs, LNG + 1 + (PMAX - 1) * (GAP + 1));
        phy_pll_lock = 1'b1;
        repeat (8) @(negedge clk);
        chk(timeout && !ready, "R11 timeout sticky", {ready, timeout}, 2'b01);

        // three lanes, new start clears previous timeout
        wakeup = 16'h00FF;
        run_ok(3, 9, 0, 0, fin);
        chk(ready && !timeout, "R11 new run clears timeout", {ready, timeout}, 2'b10);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule